// File: doc/BRIEF.md
# Serial DAC Input Interface

This block is the digital front end of a 12-bit voltage-output converter. A host sends one 16-bit word per frame over three wires: an active-low frame strobe (`frame_n`), a serial clock (`ser_clk`) and serial data (`ser_data`). The block samples all three with a faster system clock. It finds the falling edges of the serial clock and shifts one data bit on each such edge while the frame strobe is low. When the sixteenth bit arrives it loads the converter code and the operating-mode field into an output register and raises a one-cycle update strobe.

If the host releases the frame strobe before the sixteenth falling edge, the frame is dropped. The output register keeps its previous contents and no strobe is raised. After a complete word, any further serial clock edges are ignored until the strobe goes high and then low again. The analog path reads `code` and `mode` and uses `update_valid` to start a new conversion.

Top module: `serial_dac_frontend`

## Requirements
- R1: While `rst` is high and after its release, `code` is 0, `mode` is 00 (normal operation) and `update_valid` is 0 until a complete frame arrives.
- R2: Bits are taken MSB first; of the 16-bit word, bits [11:0] become `code`, bits [13:12] become `mode` (00 normal, 01/10/11 power-down variants) and bits [15:14] are discarded.
- R3: `code`, `mode` and a one-cycle `update_valid` pulse appear on the fourth rising `clk` edge, counting the first edge that samples `ser_clk` low for the sixteenth falling edge of a frame.
- R4: If `frame_n` returns high before the sixteenth falling edge, `code` and `mode` do not change and `update_valid` stays 0.
- R5: Falling `ser_clk` edges after the sixteenth one in a frame are ignored until `frame_n` goes high and then low again.
- R6: `code` and `mode` change only in the cycle in which `update_valid` is 1.
- R7: If the sixteenth falling edge and the return of `frame_n` high are first sampled on the same `clk` edge, the frame counts as aborted.
- R8: A frame that follows an aborted frame counts its bits from zero at the falling edge of `frame_n`.
- R9: Falling `ser_clk` edges while `frame_n` is high shift nothing and update nothing.
- R10: A return of `frame_n` high one `clk` cycle after the sixteenth falling edge is sampled does not prevent the update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial clock from the host, asynchronous |
| frame_n | input | 1 | Active-low frame strobe, asynchronous |
| ser_data | input | 1 | Serial data, MSB first |
| code | output | 12 | Registered converter code |
| mode | output | 2 | Registered operating mode |
| update_valid | output | 1 | One-cycle pulse when `code` and `mode` load |

## Verification
Frame completion and frame abort can fall on the same system clock when the sixteenth serial clock edge and the release of the frame strobe are sampled on the same clock edge. The bench drives both input changes in one cycle, expects no update, and then repeats the pattern with the release one cycle later, where the update must happen. A cycle-accurate behavioural model in the bench judges every clock of both cases, and directed checks compare `code`, `mode` and the number of strobes against values taken from the words sent.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
  localparam int DEF_WORD_W = 16;
  localparam int DEF_CODE_W = 12;
  localparam int DEF_MODE_W = 2;
  localparam int DEF_SYNC_STAGES = 2;

  typedef enum logic [1:0] {
    FR_IDLE  = 2'd0,
    FR_SHIFT = 2'd1,
    FR_DONE  = 2'd2
  } frame_state_e;
endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stage_q[g] <= RST_VAL;
        else     stage_q[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stage_q[g] <= RST_VAL;
        else     stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/sdac_edge.sv
module sdac_edge (
  input  logic clk,
  input  logic rst,
  input  logic sclk_lvl,
  input  logic frame_lvl,
  output logic sclk_fall,
  output logic frame_fall
);
  logic sclk_prev_q;
  logic frame_prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_prev_q  <= 1'b0;
      frame_prev_q <= 1'b1;
    end else begin
      sclk_prev_q  <= sclk_lvl;
      frame_prev_q <= frame_lvl;
    end
  end

  assign sclk_fall  = sclk_prev_q & ~sclk_lvl;
  assign frame_fall = frame_prev_q & ~frame_lvl;
endmodule

// File: rtl/sdac_shifter.sv
module sdac_shifter
  import sdac_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_fall,
  input  logic              frame_fall,
  input  logic              frame_lvl,
  input  logic              data_bit,
  output logic              word_done,
  output logic [WORD_W-1:0] word_q
);
  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WORD_W - 1);

  frame_state_e      state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-1:0] shreg_q;
  logic              take_bit;
  logic [WORD_W-1:0] shreg_nxt;

  always_comb begin
    take_bit  = ~frame_lvl & sclk_fall &
                ((state_q == FR_SHIFT) || ((state_q == FR_IDLE) && frame_fall));
    shreg_nxt = {shreg_q[WORD_W-2:0], data_bit};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= FR_IDLE;
      cnt_q     <= '0;
      shreg_q   <= '0;
      word_q    <= '0;
      word_done <= 1'b0;
    end else begin
      word_done <= 1'b0;
      if (frame_lvl) begin
        state_q <= FR_IDLE;
        cnt_q   <= '0;
      end else if (state_q == FR_IDLE && frame_fall) begin
        state_q <= FR_SHIFT;
        cnt_q   <= '0;
      end
      if (take_bit) begin
        shreg_q <= shreg_nxt;
        cnt_q   <= cnt_q + 1'b1;
        if (cnt_q == LAST_IDX) begin
          state_q   <= FR_DONE;
          word_q    <= shreg_nxt;
          word_done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sdac_outreg.sv
module sdac_outreg #(
  parameter int WORD_W = 16,
  parameter int CODE_W = 12,
  parameter int MODE_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WORD_W-1:0] word,
  output logic [CODE_W-1:0] code,
  output logic [MODE_W-1:0] mode,
  output logic              update_valid
);
  localparam int MODE_LSB = CODE_W;
  localparam int MODE_MSB = CODE_W + MODE_W - 1;

  always_ff @(posedge clk) begin
    if (rst) begin
      code         <= '0;
      mode         <= '0;
      update_valid <= 1'b0;
    end else begin
      update_valid <= load;
      if (load) begin
        code <= word[CODE_W-1:0];
        mode <= word[MODE_MSB:MODE_LSB];
      end
    end
  end
endmodule

// File: rtl/serial_dac_frontend.sv
module serial_dac_frontend
  import sdac_pkg::*;
#(
  parameter int WORD_W = DEF_WORD_W,
  parameter int CODE_W = DEF_CODE_W,
  parameter int MODE_W = DEF_MODE_W,
  parameter int SYNC_STAGES = DEF_SYNC_STAGES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_clk,
  input  logic              frame_n,
  input  logic              ser_data,
  output logic [CODE_W-1:0] code,
  output logic [MODE_W-1:0] mode,
  output logic              update_valid
);
  localparam int IN_W = 3;
  localparam logic [IN_W-1:0] IN_RST = 3'b010;

  logic [IN_W-1:0]   raw_in;
  logic [IN_W-1:0]   syn_in;
  logic              sclk_s;
  logic              frame_s;
  logic              data_s;
  logic              sclk_fall;
  logic              frame_fall;
  logic              word_done;
  logic [WORD_W-1:0] word_q;

  assign raw_in = {ser_clk, frame_n, ser_data};
  assign sclk_s  = syn_in[2];
  assign frame_s = syn_in[1];
  assign data_s  = syn_in[0];

  sdac_sync #(.W(IN_W), .STAGES(SYNC_STAGES), .RST_VAL(IN_RST)) u_sync (
    .clk(clk), .rst(rst), .d(raw_in), .q(syn_in)
  );

  sdac_edge u_edge (
    .clk(clk), .rst(rst), .sclk_lvl(sclk_s), .frame_lvl(frame_s),
    .sclk_fall(sclk_fall), .frame_fall(frame_fall)
  );

  sdac_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst(rst), .sclk_fall(sclk_fall), .frame_fall(frame_fall),
    .frame_lvl(frame_s), .data_bit(data_s), .word_done(word_done), .word_q(word_q)
  );

  sdac_outreg #(.WORD_W(WORD_W), .CODE_W(CODE_W), .MODE_W(MODE_W)) u_out (
    .clk(clk), .rst(rst), .load(word_done), .word(word_q),
    .code(code), .mode(mode), .update_valid(update_valid)
  );
endmodule

// File: rtl/sdac_checker.sv
module sdac_checker #(
  parameter int CODE_W = 12,
  parameter int MODE_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              frame_lvl,
  input logic              word_done,
  input logic [CODE_W-1:0] code,
  input logic [MODE_W-1:0] mode,
  input logic              update_valid
);
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (rst)
    update_valid |=> !update_valid);

  a_r3_follows_done: assert property (@(posedge clk) disable iff (rst)
    update_valid |-> $past(word_done));

  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    !update_valid |-> ($stable(code) && $stable(mode)));

  a_r4_no_update_when_idle: assert property (@(posedge clk) disable iff (rst)
    $past(frame_lvl, 2) |-> !update_valid);

  a_r5_done_spacing: assert property (@(posedge clk) disable iff (rst)
    word_done |=> !word_done);
endmodule

bind serial_dac_frontend sdac_checker #(.CODE_W(CODE_W), .MODE_W(MODE_W)) u_chk (
  .clk(clk), .rst(rst), .frame_lvl(frame_s), .word_done(word_done),
  .code(code), .mode(mode), .update_valid(update_valid)
);

// File: tb/tb_serial_dac_frontend.sv
module tb_serial_dac_frontend;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ser_clk = 1'b1;
  logic        frame_n = 1'b1;
  logic        ser_data = 1'b0;
  logic [11:0] code;
  logic [1:0]  mode;
  logic        update_valid;

  int total = 0;
  int bad = 0;
  int pulses = 0;
  int cyc = 0;
  bit done_flag = 0;
  string phase = "R1";

  int exp_code = 0;
  int exp_mode = 0;
  int exp_pulses = 0;

  // behavioural model state
  int m_s1c, m_s2c, m_s1f, m_s2f, m_s1d, m_s2d, m_pc, m_pf;
  int m_st, m_cnt, m_sh, m_wq, m_done, m_code, m_mode, m_upd;

  always #2 clk = ~clk;

  serial_dac_frontend dut (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .frame_n(frame_n), .ser_data(ser_data),
    .code(code), .mode(mode), .update_valid(update_valid)
  );

  always @(posedge clk) begin
    if (rst) begin
      m_s1c = 0; m_s2c = 0; m_s1f = 1; m_s2f = 1; m_s1d = 0; m_s2d = 0;
      m_pc = 0; m_pf = 1; m_st = 0; m_cnt = 0; m_sh = 0; m_wq = 0;
      m_done = 0; m_code = 0; m_mode = 0; m_upd = 0;
    end else begin
      int cf, ff, take, n_st, n_cnt, n_sh, n_wq, n_done;
      cf = (m_pc == 1 && m_s2c == 0);
      ff = (m_pf == 1 && m_s2f == 0);
      take = (m_s2f == 0) && cf && (m_st == 1 || (m_st == 0 && ff));
      m_upd = m_done;
      if (m_done != 0) begin
        m_code = m_wq % 4096;
        m_mode = (m_wq / 4096) % 4;
      end
      n_st = m_st; n_cnt = m_cnt; n_sh = m_sh; n_wq = m_wq; n_done = 0;
      if (m_s2f != 0) begin n_st = 0; n_cnt = 0; end
      else if (m_st == 0 && ff) begin n_st = 1; n_cnt = 0; end
      if (take) begin
        n_sh = (m_sh * 2 + m_s2d) % 65536;
        n_cnt = m_cnt + 1;
        if (m_cnt == 15) begin n_done = 1; n_st = 2; n_wq = n_sh; end
      end
      m_st = n_st; m_cnt = n_cnt; m_sh = n_sh; m_wq = n_wq; m_done = n_done;
      m_pc = m_s2c; m_pf = m_s2f;
      m_s2c = m_s1c; m_s2f = m_s1f; m_s2d = m_s1d;
      m_s1c = ser_clk; m_s1f = frame_n; m_s1d = ser_data;
    end
  end

  always @(negedge clk) begin
    if (!rst && !done_flag) begin
      if (update_valid) pulses++;
      total++;
      if (int'(code) != m_code || int'(mode) != m_mode || int'(update_valid) != m_upd) begin
        bad++;
        $display("FAIL %s cycle %0d: code=%h mode=%0d upd=%0b expected code=%h mode=%0d upd=%0d",
                 phase, cyc, code, mode, update_valid, m_code, m_mode, m_upd);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 60000 && !done_flag) begin
      done_flag = 1;
      bad++;
      total++;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected below 60000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp, input string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // tail = 0: frame_n released together with the last falling edge
  task automatic send(input logic [15:0] w, input int nb, input int tail);
    frame_n = 1'b1; ser_clk = 1'b1; tick(4);
    frame_n = 1'b0; tick(4);
    for (int i = 0; i < nb; i++) begin
      ser_clk = 1'b1;
      ser_data = (i < 16) ? w[15-i] : 1'b0;
      tick(4);
      ser_clk = 1'b0;
      if (i == nb - 1 && tail == 0) frame_n = 1'b1;
      if (i < nb - 1) tick(4);
    end
    if (tail > 0) tick(tail);
    frame_n = 1'b1; ser_clk = 1'b1;
    tick(16);
  endtask

  task automatic verify(input string req);
    check(req, int'(code), exp_code, "code");
    check(req, int'(mode), exp_mode, "mode");
    check(req, pulses, exp_pulses, "update pulses");
  endtask

  initial begin
    tick(3);
    check("R1", int'(code), 0, "code in reset");
    check("R1", int'(update_valid), 0, "update_valid in reset");
    @(negedge clk) rst = 1'b0;
    tick(5);
    phase = "R1";
    verify("R1");

    phase = "R2";  // reserved bits set, mode 01, code ABC
    send(16'hDABC, 16, 4);
    exp_code = 'hABC; exp_mode = 1; exp_pulses++;
    verify("R2");

    phase = "R4";  // partial frame of 10 bits
    send(16'h0555, 10, 4);
    verify("R4");

    phase = "R8";  // fresh count after abort
    send(16'h0123, 16, 4);
    exp_code = 'h123; exp_mode = 0; exp_pulses++;
    verify("R8");

    phase = "R5";  // 20 falling edges, last 4 ignored
    send(16'h2FFF, 20, 4);
    exp_code = 'hFFF; exp_mode = 2; exp_pulses++;
    verify("R5");

    phase = "R9";  // serial clock runs with frame_n high
    frame_n = 1'b1;
    for (int i = 0; i < 16; i++) begin
      ser_clk = 1'b1; ser_data = 1'b1; tick(4);
      ser_clk = 1'b0; tick(4);
    end
    ser_clk = 1'b1; tick(8);
    verify("R9");

    phase = "R7";  // 16th edge and release sampled together
    send(16'h1555, 16, 0);
    verify("R7");

    phase = "R10"; // release one cycle after the 16th edge
    send(16'h3A5A, 16, 1);
    exp_code = 'hA5A; exp_mode = 3; exp_pulses++;
    verify("R10");

    phase = "R3";  // plain frame; model compares the update cycle
    send(16'h0001, 16, 6);
    exp_code = 1; exp_mode = 0; exp_pulses++;
    verify("R3");

    phase = "R6";
    tick(20);
    verify("R6");

    done_flag = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule